// File: doc/BRIEF.md
# Additive LFSR Bit-Stream Scrambler

This block scrambles a serial bit stream travelling from a physical-layer side towards a line transceiver. It accepts one bit per clock, qualified by a valid strobe. It optionally converts the bit from NRZI line coding to plain NRZ. It then combines the bit by XOR with a keystream bit from a free-running 11-stage linear feedback shift register. Finally it either presents the result as NRZ or re-encodes it as NRZI. The keystream depends only on the register's own feedback and never on the data, so a receiver with the same generator can undo the scrambling.

Separate control inputs select the coding on the input side and on the output side. A bypass input suppresses the XOR so that data passes through unscrambled; format conversion still applies and the generator keeps running. Every stage holds its state on clocks where the strobe is low. The output register gives a fixed latency of one clock.

Top module: `lfsr_stream_scrambler`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_bit` and `out_valid` become 0. The generator state becomes all ones, the previous-line-bit memory of the input decoder becomes 0, and the output line level becomes 0.
- R2: The keystream bit is the XOR of generator stages 9 and 11, with stage 1 as the input end. On each valid clock that bit is shifted into stage 1 and every stage k moves to stage k+1.
- R3: When `bypass` is 0, the scrambled bit equals the keystream bit XOR the NRZ form of the input bit.
- R4: When `in_nrzi` is 1, the NRZ form of the input is 1 if `in_bit` differs from the line bit of the previous valid clock, and 0 otherwise. When `in_nrzi` is 0, the NRZ form is `in_bit` itself. The previous-line-bit memory updates on every valid clock in either mode.
- R5: When `out_nrzi` is 1, a valid clock inverts the output line level if the scrambled bit is 1 and keeps it if the scrambled bit is 0.
- R6: When `out_nrzi` is 0, a valid clock sets the output line level to the scrambled bit.
- R7: When `bypass` is 1, the scrambled bit equals the NRZ form of the input with no keystream applied, while the generator still advances on that clock.
- R8: On a clock with `in_valid` low, the generator, the decoder memory and `out_bit` all hold their values.
- R9: `out_valid` equals `in_valid` delayed by one clock, and `out_bit` shows the result of a valid input bit one clock after it is presented.
- R10: Starting from the all-ones seed, the keystream repeats with a period of exactly 2047 valid clocks, and each period contains 1024 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_bit | input | 1 | Serial data bit from the physical-layer side |
| in_valid | input | 1 | Qualifies `in_bit`; all state advances only when high |
| in_nrzi | input | 1 | 1: input is NRZI and is decoded; 0: input is NRZ |
| out_nrzi | input | 1 | 1: output is NRZI encoded; 0: output is NRZ |
| bypass | input | 1 | 1: scrambling suppressed (transparent data path) |
| out_bit | output | 1 | Serial output line level |
| out_valid | output | 1 | Registered copy of `in_valid` |

## Verification
The interesting collisions are a coding or bypass change that lands in the same cycle as a gap in the valid strobe, and NRZI decoding and NRZI encoding both active on one valid bit. The bench interleaves idle clocks with control changes, so a mode flip can arrive on an idle clock and take effect on the next valid one. It then checks every output bit against a bit-serial reference model that tracks the decoder memory, the generator and the line level independently of the design. A held output across a gap, with no generator step hidden inside it, shows up as exact agreement with the model on the first valid bit afterwards.

// File: rtl/scr_pkg.sv
// Package: scr_pkg
// Shared constants for the additive stream scrambler. The generator
// length and tap positions are defaults that the modules take as
// parameters; stage numbering starts at 1 at the shift-in end.
package scr_pkg;
    localparam int GEN_LEN   = 11;
    localparam int GEN_TAP_A = 9;
    localparam int GEN_TAP_B = 11;
endpackage

// File: rtl/nrzi_line_decoder.sv
// Module: nrzi_line_decoder
// Converts an incoming line bit to NRZ. In NRZI mode a 1 is produced when
// the line level differs from the level of the previous valid bit. The
// decoded bit is combinational; only the previous-level memory is stored.
// Assumes: the memory updates on every valid bit regardless of mode, so a
// mode change takes the last line level as reference.
module nrzi_line_decoder (
    input  logic clk,
    input  logic rst_n,
    input  logic line_bit,
    input  logic valid,
    input  logic nrzi_en,
    output logic nrz_bit
);
    logic prev_line;

    // Remember the last valid line level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_line <= 1'b0;
        else if (valid)
            prev_line <= line_bit;
    end

    // Pick the transition-coded or the direct bit.
    always_comb begin
        if (nrzi_en)
            nrz_bit = line_bit ^ prev_line;
        else
            nrz_bit = line_bit;
    end

    // Two equal consecutive valid NRZI line levels decode to 0.
    assert_nrzi_same_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid) && $past(rst_n) && nrzi_en && (line_bit == $past(line_bit)))
        |-> !nrz_bit);

    // The memory holds across idle clocks.
    assert_dec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(prev_line));
endmodule

// File: rtl/keystream_lfsr.sv
// Module: keystream_lfsr
// Closed-loop Fibonacci shift register producing the keystream. The key
// bit is the XOR of stages TAP_A and TAP_B and is shifted into stage 1
// on each advance. The register never sees the data.
// Assumes: taps form a primitive polynomial and the seed is nonzero.
module keystream_lfsr #(
    parameter int LEN   = scr_pkg::GEN_LEN,
    parameter int TAP_A = scr_pkg::GEN_TAP_A,
    parameter int TAP_B = scr_pkg::GEN_TAP_B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic key_bit
);
    localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

    logic [LEN-1:0] stages;
    logic [LEN-1:0] stages_nx;

    // Feedback from the two taps (stage k lives at index k-1).
    assign key_bit = stages[TAP_A-1] ^ stages[TAP_B-1];

    // Shift towards the high end, feedback enters stage 1.
    generate
        if (LEN > 1) begin : g_shift
            assign stages_nx = {stages[LEN-2:0], key_bit};
        end else begin : g_single
            assign stages_nx = key_bit;
        end
    endgenerate

    // State register: load seed on reset, step on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stages <= SEED;
        else if (advance)
            stages <= stages_nx;
    end

    // The generator never falls into the locked all-zero state.
    assert_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stages != '0);

    // The key bit of an advancing clock appears in stage 1 afterwards.
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> stages[0] == $past(key_bit));

    // Idle clocks leave the generator untouched.
    assert_gen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(stages));
endmodule

// File: rtl/nrzi_line_encoder.sv
// Module: nrzi_line_encoder
// Registers the output line level. In NRZI mode a 1 inverts the level and
// a 0 keeps it; in NRZ mode the level is the bit itself.
// Assumes: the level register is the block's only output stage, giving
// one clock of latency.
module nrzi_line_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic data_bit,
    input  logic valid,
    input  logic nrzi_en,
    output logic line_level
);
    // Update the line level on valid bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_level <= 1'b0;
        else if (valid) begin
            if (nrzi_en)
                line_level <= line_level ^ data_bit;
            else
                line_level <= data_bit;
        end
    end

    // A 1 in NRZI mode flips the level.
    assert_nrzi_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && nrzi_en && data_bit) |=> line_level != $past(line_level));

    // A 0 in NRZI mode keeps the level.
    assert_nrzi_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && nrzi_en && !data_bit) |=> $stable(line_level));

    // NRZ mode copies the bit.
    assert_nrz_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !nrzi_en) |=> line_level == $past(data_bit));
endmodule

// File: rtl/lfsr_stream_scrambler.sv
// Module: lfsr_stream_scrambler
// Top of the serial scrambler: decode (optional NRZI), XOR with the
// keystream unless bypassed, encode (optional NRZI), one clock latency.
// Assumes: one bit per clock at most; controls are sampled on each
// valid clock and may change at any time.
module lfsr_stream_scrambler #(
    parameter int GEN_LEN   = scr_pkg::GEN_LEN,
    parameter int GEN_TAP_A = scr_pkg::GEN_TAP_A,
    parameter int GEN_TAP_B = scr_pkg::GEN_TAP_B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_valid,
    input  logic in_nrzi,
    input  logic out_nrzi,
    input  logic bypass,
    output logic out_bit,
    output logic out_valid
);
    logic nrz_bit;
    logic key_bit;
    logic mix_bit;

    nrzi_line_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_bit (in_bit),
        .valid    (in_valid),
        .nrzi_en  (in_nrzi),
        .nrz_bit  (nrz_bit)
    );

    keystream_lfsr #(
        .LEN   (GEN_LEN),
        .TAP_A (GEN_TAP_A),
        .TAP_B (GEN_TAP_B)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (in_valid),
        .key_bit (key_bit)
    );

    // Apply the keystream unless the transparent path is selected.
    always_comb begin
        mix_bit = bypass ? nrz_bit : (nrz_bit ^ key_bit);
    end

    nrzi_line_encoder u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_bit   (mix_bit),
        .valid      (in_valid),
        .nrzi_en    (out_nrzi),
        .line_level (out_bit)
    );

    // Delay the strobe to line up with the output register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Strobe follows the input one clock later.
    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // Idle clocks hold the output line.
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_bit));

    // Transparent NRZ-to-NRZ path copies the input bit.
    assert_bypass_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bypass && !in_nrzi && !out_nrzi) |=> out_bit == $past(in_bit));
endmodule

// File: tb/lfsr_stream_scrambler_bench.sv
// Directed bench with a bit-serial reference model built from the requirements.
module lfsr_stream_scrambler_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, in_bit, in_valid, in_nrzi, out_nrzi, bypass;
    logic out_bit, out_valid;

    int checks = 0;
    int errors = 0;

    logic [10:0] m_gen;
    logic        m_prev;
    logic        m_level;
    logic        m_key;
    logic        seq [0:2057];

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_stream_scrambler u_lfsr_stream_scrambler (
        .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
        .in_nrzi(in_nrzi), .out_nrzi(out_nrzi), .bypass(bypass),
        .out_bit(out_bit), .out_valid(out_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model, sample after posedge.
    task automatic step(input logic b, input logic v, input logic di,
                        input logic dout, input logic byp, input string req);
        logic nrz, scr;
        @(negedge clk);
        in_bit = b; in_valid = v; in_nrzi = di; out_nrzi = dout; bypass = byp;
        m_key = m_gen[8] ^ m_gen[10];
        if (v) begin
            nrz = di ? (b ^ m_prev) : b;
            m_prev = b;
            m_gen = {m_gen[9:0], m_key};
            scr = byp ? nrz : (nrz ^ m_key);
            m_level = dout ? (m_level ^ scr) : scr;
        end
        @(posedge clk); #1;
        chk({req, " out_bit"}, out_bit, m_level);
        chk("R9 out_valid", out_valid, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; in_bit = 1; in_nrzi = 0; out_nrzi = 0; bypass = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 out_bit reset", out_bit, 0);
        chk("R1 out_valid reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1;
        m_gen = '1; m_prev = 0; m_level = 0;
    endtask

    // R2 R3 R6: NRZ in, NRZ out, zeros expose keystream, then patterns.
    task automatic test_nrz_scramble();
        do_reset();
        step(0, 1, 0, 0, 0, "R1 seed first key");
        chk("R1 seed key zero", out_bit, 0);
        for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 0, "R2 keystream");
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0, 0, "R3 ones");
        for (int i = 0; i < 40; i++) step(logic'((i * 7 + 3) % 5 < 2), 1, 0, 0, 0, "R6 pattern");
    endtask

    // R4 R5: NRZI on each side and both, with mode switches mid-stream.
    task automatic test_nrzi();
        do_reset();
        for (int i = 0; i < 30; i++) step(logic'(i % 3 == 0), 1, 1, 0, 0, "R4 decode");
        for (int i = 0; i < 30; i++) step(logic'(i % 4 < 2), 1, 0, 1, 0, "R5 encode");
        for (int i = 0; i < 30; i++) step(logic'(i % 5 == 1), 1, 1, 1, 0, "R5 both");
        for (int i = 0; i < 20; i++) step(logic'(i % 2), 1, logic'(i % 3 == 0), logic'(i % 4 == 0), 0, "R4 switching");
    endtask

    // R7: bypass copies data, generator keeps running underneath.
    task automatic test_bypass();
        do_reset();
        for (int i = 0; i < 25; i++) begin
            step(logic'(i % 3 != 1), 1, 0, 0, 1, "R7 bypass");
            chk("R7 direct copy", out_bit, (i % 3 != 1) ? 1 : 0);
        end
        for (int i = 0; i < 25; i++) step(0, 1, 0, 0, 0, "R7 key after bypass");
        for (int i = 0; i < 15; i++) step(logic'(i % 2), 1, 1, 1, 1, "R7 bypass nrzi");
    endtask

    // R8 R9: idle clocks interleaved, controls flipping on idle clocks.
    task automatic test_gaps();
        logic held;
        do_reset();
        for (int i = 0; i < 40; i++) begin
            step(logic'(i % 3 == 0), 1, logic'(i % 2), logic'(i % 5 < 2), logic'(i % 7 == 0), "R8 before gap");
            held = out_bit;
            step(~logic'(i % 3 == 0), 0, ~logic'(i % 2), 1, 1, "R8 gap");
            chk("R8 held", out_bit, held);
        end
    endtask

    // R10: period 2047 and 1024 ones, every 11-bit window unique.
    task automatic test_period();
        int ones, hits;
        do_reset();
        for (int i = 0; i < 2058; i++) begin
            step(0, 1, 0, 0, 0, "R10 run");
            seq[i] = out_bit;
        end
        ones = 0;
        for (int i = 0; i < 2047; i++) ones += int'(seq[i]);
        chk("R10 ones per period", ones, 1024);
        for (int i = 0; i < 11; i++) chk("R10 repeat at 2047", seq[i + 2047], seq[i]);
        hits = 0;
        for (int p = 0; p < 2047; p++) begin
            bit same = 1;
            for (int k = 0; k < 11; k++) if (seq[p + k] != seq[k]) same = 0;
            if (same) hits++;
        end
        chk("R10 no shorter period", hits, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; in_bit = 0; in_valid = 0; in_nrzi = 0; out_nrzi = 0; bypass = 0;
        test_nrz_scramble();
        test_nrzi();
        test_bypass();
        test_gaps();
        test_period();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule